// File: doc/BRIEF.md
# Four-Channel Byte DMA Controller

This block moves single bytes between a peripheral and a byte-wide memory on behalf of a host CPU. Each of four channels holds a 16-bit memory address and a 16-bit byte count. The CPU programs the channels through a 32-byte register window. A channel starts when its enable bit in the enable register goes from 0 to 1. Channel 0 is the only channel wired to a peripheral request line, which is typically a disk controller's data request. Each request pulse on that line moves one byte. After the byte moves, the channel address steps up by one and the count steps down by one. When the count reaches zero, the channel reports completion in its control register and can raise an interrupt.

A 4-bit page input forms the upper bits of a 20-bit memory address, with the channel address as the lower 16 bits. A configuration input selects an inverted CPU data bus. In that mode every byte the CPU writes is complemented before use, and every byte it reads is complemented before it is driven.

A small sequencer carries each transfer. It has five states:
- `XS_IDLE` waits for a request.
- `XS_P2M_WR` writes the peripheral byte to memory.
- `XS_M2P_RD` issues a memory read.
- `XS_M2P_WR` hands the memory byte to the peripheral.
- `XS_STEP` updates the channel.

It has five transitions:
- IDLE to P2M_WR or to M2P_RD when a request is accepted.
- P2M_WR to STEP.
- M2P_RD to M2P_WR.
- M2P_WR to STEP.
- STEP back to IDLE.

Top module: `dmac4_core`

## Requirements
- R1: After reset, every register in the window reads 0x00, `irq_o` is low and no memory or peripheral strobe is active.
- R2: Channel c has four byte registers at offset 4*c+k. k=0 is the address high byte, k=1 the address low byte, k=2 the count high byte and k=3 the count low byte. Each is writable, and each reads back what was last written.
- R3: The control register of channel c is at 0x10+c. A CPU write changes only bits 5:0. Bit 7 (end) and bit 6 (busy) keep their values.
- R4: The enable register is at 0x14 and stores the byte written. For each bit c that goes from 0 to 1, channel c becomes active, its busy bit 6 is set and its end bit 7 is cleared. A bit written back to 0 makes the channel inactive.
- R5: The interrupt register is at 0x15. A CPU write changes only bits 6:0, and bit 7 (interrupt active) keeps its value. The chain register at 0x16 is a plain read/write byte. Offsets 0x17 to 0x1F read 0x00 and ignore writes.
- R6: Control bit 0 selects the direction. With bit 0 = 0, a request writes the peripheral byte to memory at address page*65536 + channel address.
- R7: With control bit 0 = 1, a request reads memory at that address. The byte read is then presented to the peripheral with a one-cycle `per_wr_o` pulse.
- R8: Each byte moved increments the channel address by 1, wrapping within 16 bits, and decrements the count by 1.
- R9: When the count reaches zero, end bit 7 is set and busy bit 6 is cleared. If interrupt register bit c is 1 for that channel, interrupt bit 7 is set and `irq_o` goes high. Otherwise `irq_o` stays low.
- R10: A CPU read of a control register returns its current value and then clears that channel's end bit. It also clears interrupt bit 7, which drops `irq_o`.
- R11: A request is ignored in three cases: while channel 0 is inactive, while its count is zero, or while a transfer is still in progress. An ignored request produces no strobe and no change of address or count.
- R12: With `cfg_bus_inv` high, written bytes are stored complemented and read bytes are driven complemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus_inv | input | 1 | Inverted CPU data bus mode |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 5 | Register window offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Addressed register value (combinational) |
| irq_o | output | 1 | Interrupt request |
| page_i | input | 4 | Memory page, upper address bits |
| dreq_i | input | 1 | Peripheral transfer request for channel 0 |
| per_rdata_i | input | 8 | Byte from the peripheral |
| per_wr_o | output | 1 | Byte for the peripheral is valid |
| per_wdata_o | output | 8 | Byte for the peripheral |
| mem_addr_o | output | 20 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe (data valid next cycle) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
Register writes take effect at the accepting edge, and `cpu_rdata` follows the address combinationally. The bench therefore reads registers half a cycle after setting the address, and it never asserts the strobe unless it intends the clear-on-read side effect.

A request accepted at edge E0 produces the following timing:
- A peripheral-to-memory request gives `mem_we_o` in the cycle after E0, and the address, count, end flag and interrupt change at E2.
- A memory-to-peripheral request gives `mem_re_o` after E0, `per_wr_o` after E1, and its updates at E3.

The bench drives each request on a falling edge and waits four further falling edges before it inspects registers. A scoreboard monitor compares every memory write and peripheral hand-off on the falling edge against the queued expected address and byte. Any event with no matching expectation counts as a failure, so ignored requests are checked by their absence.

// File: rtl/dmac4_pkg.sv
package dmac4_pkg;

    // Control register bit positions
    localparam int unsigned CTL_END_BIT  = 7;
    localparam int unsigned CTL_BUSY_BIT = 6;
    localparam int unsigned CTL_DIR_BIT  = 0;
    localparam int unsigned CTL_SW_MSB   = 5;

    // Interrupt register: bit 7 is the hardware-owned active flag
    localparam int unsigned IRQ_FLAG_BIT = 7;

    // Window offsets for the global registers
    localparam logic [4:0] OFS_ENABLE = 5'h14;
    localparam logic [4:0] OFS_IRQ    = 5'h15;
    localparam logic [4:0] OFS_CHAIN  = 5'h16;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_P2M_WR,
        XS_M2P_RD,
        XS_M2P_WR,
        XS_STEP
    } xfer_state_e;

    typedef enum logic [1:0] {
        FLD_ADDR_HI = 2'd0,
        FLD_ADDR_LO = 2'd1,
        FLD_CNT_HI  = 2'd2,
        FLD_CNT_LO  = 2'd3
    } chan_field_e;

endpackage

// File: rtl/dmac4_chan.sv
module dmac4_chan
    import dmac4_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fld_we_i,
    input  logic [1:0]            fld_sel_i,
    input  logic                  ctl_we_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  start_i,
    input  logic                  step_i,
    input  logic                  ctl_rd_i,
    output logic [2*DATA_W-1:0]   addr_o,
    output logic [2*DATA_W-1:0]   count_o,
    output logic [DATA_W-1:0]     ctl_o,
    output logic                  term_o
);

    localparam int CH_W = 2 * DATA_W;

    logic [CH_W-1:0]   addr_q;
    logic [CH_W-1:0]   count_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] ctl_d;

    // Last byte of the block: count is about to reach zero
    assign term_o = step_i && (count_q == CH_W'(1));

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we_i) begin
            ctl_d[CTL_SW_MSB:0] = wdata_i[CTL_SW_MSB:0];
        end
        if (ctl_rd_i) begin
            ctl_d[CTL_END_BIT] = 1'b0;
        end
        if (start_i) begin
            ctl_d[CTL_BUSY_BIT] = 1'b1;
            ctl_d[CTL_END_BIT]  = 1'b0;
        end
        if (term_o) begin
            ctl_d[CTL_BUSY_BIT] = 1'b0;
            ctl_d[CTL_END_BIT]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            ctl_q   <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (step_i) begin
                addr_q  <= addr_q + 1'b1;
                count_q <= count_q - 1'b1;
            end else if (fld_we_i) begin
                unique case (chan_field_e'(fld_sel_i))
                    FLD_ADDR_HI: addr_q[CH_W-1:DATA_W]  <= wdata_i;
                    FLD_ADDR_LO: addr_q[DATA_W-1:0]     <= wdata_i;
                    FLD_CNT_HI:  count_q[CH_W-1:DATA_W] <= wdata_i;
                    FLD_CNT_LO:  count_q[DATA_W-1:0]    <= wdata_i;
                endcase
            end
        end
    end

    assign addr_o  = addr_q;
    assign count_o = count_q;
    assign ctl_o   = ctl_q;

    assert_step_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (addr_q == ($past(addr_q) + 1'b1)) && (count_q == ($past(count_q) - 1'b1)));

    assert_term_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> ctl_q[CTL_END_BIT] && !ctl_q[CTL_BUSY_BIT]);

    assert_ctl_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && !step_i && !start_i && !ctl_rd_i)
        |=> (ctl_q[CTL_END_BIT:CTL_BUSY_BIT] == $past(ctl_q[CTL_END_BIT:CTL_BUSY_BIT])));

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !term_o) |=> ctl_q[CTL_BUSY_BIT] && !ctl_q[CTL_END_BIT]);

endmodule

// File: rtl/dmac4_xfer.sv
module dmac4_xfer
    import dmac4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_i,
    input  logic                            active_i,
    input  logic                            dir_i,
    input  logic [2*DATA_W-1:0]             count_i,
    input  logic [2*DATA_W-1:0]             addr_i,
    input  logic [PAGE_W-1:0]               page_i,
    input  logic [DATA_W-1:0]               per_rdata_i,
    input  logic [DATA_W-1:0]               mem_rdata_i,
    output logic [2*DATA_W+PAGE_W-1:0]      mem_addr_o,
    output logic                            mem_we_o,
    output logic                            mem_re_o,
    output logic [DATA_W-1:0]               mem_wdata_o,
    output logic                            per_wr_o,
    output logic [DATA_W-1:0]               per_wdata_o,
    output logic                            step_o
);

    localparam int CH_W   = 2 * DATA_W;
    localparam int MEM_AW = CH_W + PAGE_W;

    xfer_state_e       state_q;
    xfer_state_e       state_d;
    logic [DATA_W-1:0] byte_q;
    logic              accept;

    assign accept = (state_q == XS_IDLE) && req_i && active_i && (count_i != '0);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:   if (accept) state_d = dir_i ? XS_M2P_RD : XS_P2M_WR;
            XS_P2M_WR: state_d = XS_STEP;
            XS_M2P_RD: state_d = XS_M2P_WR;
            XS_M2P_WR: state_d = XS_STEP;
            XS_STEP:   state_d = XS_IDLE;
            default:   state_d = XS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Peripheral byte captured when the request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (accept) begin
            byte_q <= per_rdata_i;
        end
    end

    // Outputs
    always_comb begin
        mem_we_o = 1'b0;
        mem_re_o = 1'b0;
        per_wr_o = 1'b0;
        step_o   = 1'b0;
        unique case (state_q)
            XS_IDLE:   ;
            XS_P2M_WR: mem_we_o = 1'b1;
            XS_M2P_RD: mem_re_o = 1'b1;
            XS_M2P_WR: per_wr_o = 1'b1;
            XS_STEP:   step_o   = 1'b1;
            default:   ;
        endcase
    end

    assign mem_addr_o  = {page_i, {CH_W{1'b0}}} + MEM_AW'(addr_i);
    assign mem_wdata_o = byte_q;
    assign per_wdata_o = mem_rdata_i;

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_re_o, per_wr_o, step_o}));

    assert_m2p_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> per_wr_o);

    assert_p2m_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> step_o);

    assert_ignore_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == XS_IDLE) && (count_i == '0)) |=> (state_q == XS_IDLE));

endmodule

// File: rtl/dmac4_core.sv
module dmac4_core
    import dmac4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4,
    parameter int N_CHAN = 4,
    parameter int WIN_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_bus_inv,
    input  logic                          cpu_sel,
    input  logic                          cpu_we,
    input  logic [WIN_W-1:0]              cpu_addr,
    input  logic [DATA_W-1:0]             cpu_wdata,
    output logic [DATA_W-1:0]             cpu_rdata,
    output logic                          irq_o,
    input  logic [PAGE_W-1:0]             page_i,
    input  logic                          dreq_i,
    input  logic [DATA_W-1:0]             per_rdata_i,
    output logic                          per_wr_o,
    output logic [DATA_W-1:0]             per_wdata_o,
    output logic [2*DATA_W+PAGE_W-1:0]    mem_addr_o,
    output logic                          mem_we_o,
    output logic                          mem_re_o,
    output logic [DATA_W-1:0]             mem_wdata_o,
    input  logic [DATA_W-1:0]             mem_rdata_i
);

    localparam int CH_W = 2 * DATA_W;
    localparam int CI_W = $clog2(N_CHAN);

    logic [DATA_W-1:0] wdata_eff;
    logic [DATA_W-1:0] rd_raw;
    logic              cpu_wr;
    logic              cpu_rd;
    logic              ctl_space;

    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] irqc_q;
    logic [DATA_W-1:0] irqc_d;
    logic [DATA_W-1:0] chain_q;

    logic [CH_W-1:0]   ch_addr  [N_CHAN];
    logic [CH_W-1:0]   ch_count [N_CHAN];
    logic [DATA_W-1:0] ch_ctl   [N_CHAN];
    logic [N_CHAN-1:0] ch_term;
    logic [N_CHAN-1:0] ch_ctl_rd;
    logic              xfer_step;
    logic              term_irq;

    assign wdata_eff = cfg_bus_inv ? ~cpu_wdata : cpu_wdata;
    assign cpu_wr    = cpu_sel && cpu_we;
    assign cpu_rd    = cpu_sel && !cpu_we;
    assign ctl_space = (cpu_addr[WIN_W-1:2] == 3'b100);

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic fld_we;
        logic ctl_we;
        logic start;
        logic step;

        assign fld_we       = cpu_wr && !cpu_addr[WIN_W-1] && (cpu_addr[3:2] == CI_W'(c));
        assign ctl_we       = cpu_wr && ctl_space && (cpu_addr[1:0] == CI_W'(c));
        assign ch_ctl_rd[c] = cpu_rd && ctl_space && (cpu_addr[1:0] == CI_W'(c));
        assign start        = cpu_wr && (cpu_addr == OFS_ENABLE) && wdata_eff[c] && !enable_q[c];

        if (c == 0) begin : g_xfer_step
            assign step = xfer_step;
        end else begin : g_no_step
            assign step = 1'b0;
        end

        dmac4_chan #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .fld_we_i  (fld_we),
            .fld_sel_i (cpu_addr[1:0]),
            .ctl_we_i  (ctl_we),
            .wdata_i   (wdata_eff),
            .start_i   (start),
            .step_i    (step),
            .ctl_rd_i  (ch_ctl_rd[c]),
            .addr_o    (ch_addr[c]),
            .count_o   (ch_count[c]),
            .ctl_o     (ch_ctl[c]),
            .term_o    (ch_term[c])
        );
    end

    dmac4_xfer #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (dreq_i),
        .active_i    (enable_q[0]),
        .dir_i       (ch_ctl[0][CTL_DIR_BIT]),
        .count_i     (ch_count[0]),
        .addr_i      (ch_addr[0]),
        .page_i      (page_i),
        .per_rdata_i (per_rdata_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_wdata_o (mem_wdata_o),
        .per_wr_o    (per_wr_o),
        .per_wdata_o (per_wdata_o),
        .step_o      (xfer_step)
    );

    assign term_irq = |(ch_term & irqc_q[N_CHAN-1:0]);

    always_comb begin
        irqc_d = irqc_q;
        if (cpu_wr && (cpu_addr == OFS_IRQ)) begin
            irqc_d[IRQ_FLAG_BIT-1:0] = wdata_eff[IRQ_FLAG_BIT-1:0];
        end
        if (|ch_ctl_rd) begin
            irqc_d[IRQ_FLAG_BIT] = 1'b0;
        end
        if (term_irq) begin
            irqc_d[IRQ_FLAG_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            irqc_q   <= '0;
            chain_q  <= '0;
        end else begin
            irqc_q <= irqc_d;
            if (cpu_wr && (cpu_addr == OFS_ENABLE)) enable_q <= wdata_eff;
            if (cpu_wr && (cpu_addr == OFS_CHAIN))  chain_q  <= wdata_eff;
        end
    end

    always_comb begin
        rd_raw = '0;
        if (!cpu_addr[WIN_W-1]) begin
            unique case (chan_field_e'(cpu_addr[1:0]))
                FLD_ADDR_HI: rd_raw = ch_addr[cpu_addr[3:2]][CH_W-1:DATA_W];
                FLD_ADDR_LO: rd_raw = ch_addr[cpu_addr[3:2]][DATA_W-1:0];
                FLD_CNT_HI:  rd_raw = ch_count[cpu_addr[3:2]][CH_W-1:DATA_W];
                FLD_CNT_LO:  rd_raw = ch_count[cpu_addr[3:2]][DATA_W-1:0];
            endcase
        end else if (ctl_space) begin
            rd_raw = ch_ctl[cpu_addr[1:0]];
        end else if (cpu_addr == OFS_ENABLE) begin
            rd_raw = enable_q;
        end else if (cpu_addr == OFS_IRQ) begin
            rd_raw = irqc_q;
        end else if (cpu_addr == OFS_CHAIN) begin
            rd_raw = chain_q;
        end
    end

    assign cpu_rdata = cfg_bus_inv ? ~rd_raw : rd_raw;
    assign irq_o     = irqc_q[IRQ_FLAG_BIT];

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(term_irq));

    assert_ctl_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_ctl_rd) && !term_irq) |=> !irq_o);

    assert_irq_keep_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr == OFS_IRQ) && !(|ch_ctl_rd) && !term_irq) |=> $stable(irq_o));

endmodule

// File: tb/dmac4_core_tb_top.sv
`timescale 1ns/1ps
module dmac4_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus_inv = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_we = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        irq_o;
    logic [3:0]  page_i = '0;
    logic        dreq_i = 1'b0;
    logic [7:0]  per_rdata_i = '0;
    logic        per_wr_o;
    logic [7:0]  per_wdata_o;
    logic [19:0] mem_addr_o;
    logic        mem_we_o;
    logic        mem_re_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  mem_arr [256];
    logic [28:0] exp_q [$];
    logic [7:0]  rd;

    always #2 clk = ~clk;

    dmac4_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bus_inv(cfg_bus_inv),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_o(irq_o),
        .page_i(page_i), .dreq_i(dreq_i), .per_rdata_i(per_rdata_i),
        .per_wr_o(per_wr_o), .per_wdata_o(per_wdata_o),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = 8'(i) ^ 8'h5A;
    end

    // Memory model: read data valid the cycle after the read strobe
    always @(posedge clk) begin
        if (mem_re_o) mem_rdata_i <= mem_arr[mem_addr_o[7:0]];
        if (mem_we_o) mem_arr[mem_addr_o[7:0]] <= mem_wdata_o;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: kind 0 = memory write, kind 1 = peripheral hand-off
    always @(negedge clk) begin
        if (rst_n && (mem_we_o || per_wr_o)) begin
            logic [28:0] got;
            got = mem_we_o ? {1'b0, mem_addr_o, mem_wdata_o} : {1'b1, mem_addr_o, per_wdata_o};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6/R7/R11 unexpected event actual=%h expected=none", got);
            end else begin
                logic [28:0] want;
                want = exp_q.pop_front();
                if (got !== want) begin
                    n_fail++;
                    $display("FAIL R6/R7 transfer actual=%h expected=%h", got, want);
                end
            end
        end
    end

    task automatic expect_evt(input logic kind, input logic [19:0] a, input logic [7:0] d);
        exp_q.push_back({kind, a, d});
    endtask

    task automatic cpu_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic cpu_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] b);
        @(negedge clk);
        dreq_i = 1'b1; per_rdata_i = b;
        @(negedge clk);
        dreq_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 32; a += 5) begin
            peek(5'(a), rd); check("R1 reset read", rd, 8'h00);
        end
        check("R1 irq low", irq_o, 1'b0);
        check("R1 no strobes", {mem_we_o, mem_re_o, per_wr_o}, 3'b000);

        // R2: channel 2 byte registers
        cpu_write(5'h08, 8'hDE); cpu_write(5'h09, 8'hAD);
        cpu_write(5'h0A, 8'hBE); cpu_write(5'h0B, 8'hEF);
        peek(5'h08, rd); check("R2 addr hi", rd, 8'hDE);
        peek(5'h09, rd); check("R2 addr lo", rd, 8'hAD);
        peek(5'h0A, rd); check("R2 cnt hi", rd, 8'hBE);
        peek(5'h0B, rd); check("R2 cnt lo", rd, 8'hEF);

        // R3: control write keeps bits 7:6
        cpu_write(5'h13, 8'hFF);
        peek(5'h13, rd); check("R3 ctl low bits only", rd, 8'h3F);

        // R5: interrupt, chain, unused
        cpu_write(5'h15, 8'hFE);
        peek(5'h15, rd); check("R5 irq reg bit7 kept", rd, 8'h7E);
        cpu_write(5'h16, 8'hA5);
        peek(5'h16, rd); check("R5 chain rw", rd, 8'hA5);
        cpu_write(5'h1A, 8'h55);
        peek(5'h1A, rd); check("R5 unused reads 0", rd, 8'h00);
        peek(5'h16, rd); check("R5 unused write ignored", rd, 8'hA5);

        // R4, R6, R8, R9: peripheral-to-memory on channel 0
        cpu_write(5'h00, 8'h12); cpu_write(5'h01, 8'h34);
        cpu_write(5'h02, 8'h00); cpu_write(5'h03, 8'h03);
        cpu_write(5'h10, 8'h00); cpu_write(5'h15, 8'h01);
        page_i = 4'h9;
        cpu_write(5'h14, 8'h01);
        peek(5'h10, rd); check("R4 start sets busy", rd, 8'h40);
        peek(5'h14, rd); check("R4 enable stored", rd, 8'h01);
        expect_evt(1'b0, 20'h91234, 8'hA1);
        expect_evt(1'b0, 20'h91235, 8'hB2);
        expect_evt(1'b0, 20'h91236, 8'hC3);
        pulse_req(8'hA1); pulse_req(8'hB2); pulse_req(8'hC3);
        peek(5'h01, rd); check("R8 addr advanced", rd, 8'h37);
        peek(5'h03, rd); check("R8 count reached 0", rd, 8'h00);
        peek(5'h10, rd); check("R9 end set busy cleared", rd, 8'h80);
        check("R9 irq raised", irq_o, 1'b1);
        peek(5'h15, rd); check("R9 irq flag bit7", rd, 8'h81);

        // R11: request at zero count ignored
        pulse_req(8'hEE);
        peek(5'h01, rd); check("R11 zero count addr kept", rd, 8'h37);

        // R10: clearing read
        cpu_read(5'h10, rd); check("R10 read returns value", rd, 8'h80);
        peek(5'h10, rd); check("R10 end cleared", rd, 8'h00);
        check("R10 irq dropped", irq_o, 1'b0);
        peek(5'h15, rd); check("R10 irq flag cleared", rd, 8'h01);

        // R7, R8: memory-to-peripheral with address wrap
        cpu_write(5'h14, 8'h00);
        cpu_write(5'h00, 8'hFF); cpu_write(5'h01, 8'hFF);
        cpu_write(5'h02, 8'h00); cpu_write(5'h03, 8'h02);
        cpu_write(5'h10, 8'h01);
        page_i = 4'h2;
        cpu_write(5'h14, 8'h01);
        expect_evt(1'b1, 20'h2FFFF, 8'hA5);
        expect_evt(1'b1, 20'h20000, 8'h5A);
        pulse_req(8'h00); pulse_req(8'h00);
        peek(5'h00, rd); check("R8 addr wrap hi", rd, 8'h00);
        peek(5'h01, rd); check("R8 addr wrap lo", rd, 8'h01);
        peek(5'h10, rd); check("R9 m2p end flags", rd, 8'h81);
        cpu_read(5'h10, rd);

        // R9: terminal count with channel interrupt disabled
        cpu_write(5'h15, 8'h00);
        cpu_write(5'h14, 8'h00);
        cpu_write(5'h03, 8'h01); cpu_write(5'h10, 8'h00);
        cpu_write(5'h14, 8'h01);
        expect_evt(1'b0, 20'h20001, 8'h77);
        pulse_req(8'h77);
        peek(5'h10, rd); check("R9 end without irq", rd, 8'h80);
        check("R9 irq stays low", irq_o, 1'b0);

        // R4: re-enable clears end; R11: request during transfer ignored
        cpu_write(5'h14, 8'h00);
        cpu_write(5'h03, 8'h05);
        cpu_write(5'h14, 8'h01);
        peek(5'h10, rd); check("R4 restart clears end", rd, 8'h40);
        expect_evt(1'b0, 20'h20002, 8'h11);
        @(negedge clk); dreq_i = 1'b1; per_rdata_i = 8'h11;
        @(negedge clk); per_rdata_i = 8'h22;
        @(negedge clk); dreq_i = 1'b0;
        repeat (4) @(negedge clk);
        peek(5'h03, rd); check("R11 busy request ignored", rd, 8'h04);

        // R4, R11: inactive channel ignores requests
        cpu_write(5'h14, 8'h00);
        pulse_req(8'h33);
        peek(5'h03, rd); check("R11 inactive count kept", rd, 8'h04);
        peek(5'h01, rd); check("R4 disabled addr kept", rd, 8'h03);

        // R12: inverted bus
        cfg_bus_inv = 1'b1;
        cpu_write(5'h16, 8'h0F);
        peek(5'h16, rd); check("R12 inverted readback", rd, 8'h0F);
        peek(5'h1A, rd); check("R12 inverted zero reads FF", rd, 8'hFF);
        cfg_bus_inv = 1'b0;
        peek(5'h16, rd); check("R12 stored complemented", rd, 8'hF0);

        check("R6 R7 all expected events seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule